// File: doc/BRIEF.md
# Two-Level Weighted Cell Scheduler

This block decides which cell goes out next from a set of per-destination queues. Each queue is split into four delay-priority subqueues. For every subqueue the surrounding logic supplies an empty flag and a backpressure flag. On each request pulse the block makes one choice and returns a registered grant that carries the chosen queue index and priority index. Cell storage and header handling stay with the caller.

The choice is made at two levels. The outer level is a circular round-robin over the queues. It skips any queue that has nothing it may send. The inner level works inside the chosen queue. Each queue has its own 16-slot sequence table, and each slot names a priority. The count of slots that name a priority sets that priority's share of the queue's service. If the priority named by the current slot cannot send, the most urgent priority that can send is served instead. The tables are loaded through a one-cycle write port.

Top module: `wrr_cell_sched`

## Requirements
- R1: After reset, gnt_o is 0, the outer pointer points at queue 0, every slot pointer is 0, and slot s of every table holds priority s mod 4.
- R2: A grant is issued only for a request: when req_i is sampled high at a rising edge and some subqueue is eligible, gnt_o is 1 for the following cycle with gnt_q_o and gnt_p_o valid. Without a request gnt_o stays 0.
- R3: The flags for queue q, priority p sit at bit q*4+p of empty_i and bp_i. That subqueue is eligible only when both of its bits are 0.
- R4: The outer search starts at the queue after the last granted one and wraps from the highest index to 0. A queue with no eligible subqueue is passed over.
- R5: When a request finds no eligible subqueue, no grant is issued, and neither the outer pointer nor any slot pointer moves.
- R6: Within the chosen queue, the priority stored in the slot at the queue's slot pointer is granted if that subqueue is eligible.
- R7: If the slotted priority is not eligible, the lowest-numbered eligible priority of that queue is granted. Priority 0 is the most urgent.
- R8: A queue's 4-bit slot pointer advances by one, wrapping from 15 to 0, on every grant to that queue, including fallback grants. The pointers of other queues hold.
- R9: When cfg_we_i is sampled high, cfg_prio_i is stored in slot cfg_slot_i of queue cfg_q_i. A decision made in that same cycle still sees the old entry, and later decisions see the new one.
- R10: A write to one queue's table leaves the tables of all other queues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request for one scheduling decision |
| empty_i | input | NUM_Q*4 | Subqueue empty flags, bit q*4+p |
| bp_i | input | NUM_Q*4 | Subqueue backpressure flags, bit q*4+p |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_q_i | input | $clog2(NUM_Q) | Queue whose table is written |
| cfg_slot_i | input | 4 | Slot written |
| cfg_prio_i | input | 2 | Priority code stored in the slot |
| gnt_o | output | 1 | Grant valid, one cycle per granted request |
| gnt_q_o | output | $clog2(NUM_Q) | Granted queue index |
| gnt_p_o | output | 2 | Granted priority index |

## Verification
A grant comes from the rising edge that samples the request, so gnt_o and its indices are due exactly one edge after the request. The pointers and any table write take effect at that same edge. The bench changes inputs only on falling edges and reads the grant on the next falling edge, so each read falls after exactly one register stage. A bench model of the tables and pointers, built from the requirements, supplies each expected value. It is updated only after the read, which also covers the case where a write and a request share a cycle. An idle request or a cycle with no request is followed by a grant with the flags all eligible, which shows through the ports that no pointer moved.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;
  localparam int PRIO_N = 4;
  localparam int PRIO_W = $clog2(PRIO_N);
  localparam int SLOT_N = 16;
  localparam int SLOT_W = $clog2(SLOT_N);

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/wrr_slot_table.sv
module wrr_slot_table
  import wrr_sched_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  slot_t wr_slot_i,
  input  prio_t wr_prio_i,
  input  logic  adv_i,
  output prio_t cur_prio_o
);
  prio_t tbl_q [SLOT_N];
  slot_t ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOT_N; s++) tbl_q[s] <= prio_t'(s % PRIO_N);
      ptr_q <= '0;
    end else begin
      if (wr_en_i) tbl_q[wr_slot_i] <= wr_prio_i;
      if (adv_i)   ptr_q <= ptr_q + 1'b1;
    end
  end

  assign cur_prio_o = tbl_q[ptr_q];

  AST_SLOT_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q)); // R8
  AST_SLOT_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_q == slot_t'($past(ptr_q) + 1)); // R8
endmodule

// File: rtl/wrr_prio_pick.sv
module wrr_prio_pick
  import wrr_sched_pkg::*;
(
  input  logic [PRIO_N-1:0] ok_i,
  input  prio_t             sched_i,
  output prio_t             pick_o
);
  // slotted priority first, else most urgent eligible
  always_comb begin
    pick_o = sched_i;
    if (!ok_i[sched_i]) begin
      pick_o = '0;
      for (int p = PRIO_N-1; p >= 0; p--) begin
        if (ok_i[p]) pick_o = prio_t'(p);
      end
    end
  end
endmodule

// File: rtl/wrr_queue_rr.sv
module wrr_queue_rr #(
  parameter int NUM_Q = 8,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_Q-1:0] elig_i,
  input  logic             adv_i,
  output logic             any_o,
  output logic [QW-1:0]    sel_o
);
  logic [QW-1:0] ptr_q;

  // downward scan so the smallest offset from ptr_q wins
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int i = NUM_Q-1; i >= 0; i--) begin
      if (elig_i[(int'(ptr_q) + i) % NUM_Q]) begin
        any_o = 1'b1;
        sel_o = QW'((int'(ptr_q) + i) % NUM_Q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (sel_o == QW'(NUM_Q-1)) ? '0 : sel_o + 1'b1;
  end

  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q)); // R4
  AST_ADV_NEEDS_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> |elig_i); // R5
endmodule

// File: rtl/wrr_cell_sched.sv
module wrr_cell_sched
  import wrr_sched_pkg::*;
#(
  parameter int NUM_Q = 8,
  localparam int QW = $clog2(NUM_Q),
  localparam int NB = NUM_Q * PRIO_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [NB-1:0] empty_i,
  input  logic [NB-1:0] bp_i,
  input  logic          cfg_we_i,
  input  logic [QW-1:0] cfg_q_i,
  input  logic [3:0]    cfg_slot_i,
  input  logic [1:0]    cfg_prio_i,
  output logic          gnt_o,
  output logic [QW-1:0] gnt_q_o,
  output logic [1:0]    gnt_p_o
);
  logic [NB-1:0]    sq_ok;
  logic [NUM_Q-1:0] q_elig;
  prio_t            cur_prio [NUM_Q];
  logic             any_elig;
  logic [QW-1:0]    sel_q;
  logic             take;
  prio_t            pick_p;

  assign sq_ok = ~empty_i & ~bp_i;
  assign take  = req_i & any_elig;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    assign q_elig[q] = |sq_ok[q*PRIO_N +: PRIO_N];

    wrr_slot_table u_tbl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (cfg_we_i && (cfg_q_i == QW'(q))),
      .wr_slot_i  (slot_t'(cfg_slot_i)),
      .wr_prio_i  (prio_t'(cfg_prio_i)),
      .adv_i      (take && (sel_q == QW'(q))),
      .cur_prio_o (cur_prio[q])
    );
  end

  wrr_queue_rr #(.NUM_Q(NUM_Q)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (q_elig),
    .adv_i  (take),
    .any_o  (any_elig),
    .sel_o  (sel_q)
  );

  wrr_prio_pick u_pick (
    .ok_i    (sq_ok[int'(sel_q)*PRIO_N +: PRIO_N]),
    .sched_i (cur_prio[sel_q]),
    .pick_o  (pick_p)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o   <= 1'b0;
      gnt_q_o <= '0;
      gnt_p_o <= '0;
    end else begin
      gnt_o <= take;
      if (take) begin
        gnt_q_o <= sel_q;
        gnt_p_o <= 2'(pick_p);
      end
    end
  end

  AST_GNT_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> $past(req_i)); // R2
  AST_GNT_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> |($past(sq_ok) & (NB'(1) << (int'(gnt_q_o)*PRIO_N + int'(gnt_p_o))))); // R3
  AST_IDLE_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(|sq_ok)) |=> !gnt_o); // R5
endmodule

// File: tb/wrr_cell_sched_tb.sv
`timescale 1ns/1ps
module wrr_cell_sched_tb_top;
  localparam int NQ = 8;
  localparam int QW = 3;
  localparam int NB = NQ * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [NB-1:0] empty = '1;
  logic [NB-1:0] bp = '0;
  logic          cfg_we = 1'b0;
  logic [QW-1:0] cfg_q = '0;
  logic [3:0]    cfg_slot = '0;
  logic [1:0]    cfg_prio = '0;
  logic          gnt;
  logic [QW-1:0] gnt_q;
  logic [1:0]    gnt_p;

  int checks = 0;
  int errors = 0;
  int m_tbl [NQ][16];
  int m_ptr [NQ];
  int m_rr;

  always #4 clk = ~clk;

  wrr_cell_sched #(.NUM_Q(NQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .empty_i(empty), .bp_i(bp),
    .cfg_we_i(cfg_we), .cfg_q_i(cfg_q), .cfg_slot_i(cfg_slot), .cfg_prio_i(cfg_prio),
    .gnt_o(gnt), .gnt_q_o(gnt_q), .gnt_p_o(gnt_p)
  );

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic bit ok_bit(logic [NB-1:0] e, logic [NB-1:0] b, int q, int p);
    return !e[q*4+p] && !b[q*4+p];
  endfunction

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_ptr[q] = 0;
      for (int s = 0; s < 16; s++) m_tbl[q][s] = s % 4;
    end
    m_rr = 0;
  endtask

  // expected decision from the requirement rules
  task automatic model_pick(input logic [NB-1:0] e, input logic [NB-1:0] b,
                            output bit g, output int eq, output int ep);
    g = 0; eq = 0; ep = 0;
    for (int i = 0; i < NQ && !g; i++) begin
      int q = (m_rr + i) % NQ;
      for (int p = 0; p < 4; p++) if (ok_bit(e, b, q, p)) g = 1;
      if (g) begin
        eq = q;
        ep = m_tbl[q][m_ptr[q]];
        if (!ok_bit(e, b, q, ep)) begin
          for (int p = 3; p >= 0; p--) if (ok_bit(e, b, q, p)) ep = p;
        end
      end
    end
  endtask

  // starts and ends just after a falling edge
  task automatic issue(logic [NB-1:0] e, logic [NB-1:0] b, string r,
                       bit wr = 0, int wq = 0, int ws = 0, int wp = 0);
    bit g; int eq; int ep;
    model_pick(e, b, g, eq, ep);
    empty = e; bp = b; req = 1'b1;
    if (wr) begin cfg_we = 1'b1; cfg_q = QW'(wq); cfg_slot = 4'(ws); cfg_prio = 2'(wp); end
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    chk(r, "gnt_o", int'(gnt), int'(g));
    if (g) begin
      chk(r, "gnt_q_o", int'(gnt_q), eq);
      chk(r, "gnt_p_o", int'(gnt_p), ep);
      m_ptr[eq] = (m_ptr[eq] + 1) % 16;
      m_rr = (eq + 1) % NQ;
    end
    if (wr) m_tbl[wq][ws] = wp;
  endtask

  task automatic write_slot(int q, int s, int p);
    cfg_we = 1'b1; cfg_q = QW'(q); cfg_slot = 4'(s); cfg_prio = 2'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    m_tbl[q][s] = p;
  endtask

  function automatic logic [NB-1:0] only_q(logic [NB-1:0] base, int q, logic [3:0] v);
    logic [NB-1:0] r = base;
    r[q*4 +: 4] = v;
    return r;
  endfunction

  task automatic t_reset();
    chk("R1", "gnt_o after reset", int'(gnt), 0);
    issue('0, '0, "R1");               // queue 0, slot 0 -> prio 0
  endtask

  task automatic t_rr_all();
    for (int i = 0; i < 10; i++) issue('0, '0, "R4 R6");
  endtask

  task automatic t_skip();
    logic [NB-1:0] e = '1;
    logic [NB-1:0] b = '0;
    e = only_q(e, 2, 4'b0000);
    e = only_q(e, 5, 4'b0000);
    e = only_q(e, 6, 4'b0000);
    b = only_q(b, 6, 4'b1111);        // nonempty but fully backpressured
    for (int i = 0; i < 4; i++) issue(e, b, "R4 R3");
  endtask

  task automatic t_idle();
    issue('1, '0, "R5");
    issue('0, '1, "R5");
    issue('0, '0, "R5");               // pointers unmoved
  endtask

  task automatic t_noreq();
    empty = '0; bp = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "gnt_o without req", int'(gnt), 0);
    end
    issue('0, '0, "R2");
  endtask

  task automatic t_fallback();
    logic [NB-1:0] e = only_q('1, 6, 4'b0010);
    logic [NB-1:0] b = only_q('0, 6, 4'b0001);
    for (int i = 0; i < 6; i++) issue(e, b, "R7 R3");
  endtask

  task automatic t_wrap();
    logic [NB-1:0] e = only_q('1, 1, 4'b0000);
    for (int i = 0; i < 18; i++) issue(e, '0, "R8");
  endtask

  task automatic t_write();
    logic [NB-1:0] e = only_q(only_q('1, 3, 4'b0000), 4, 4'b0000);
    for (int s = 0; s < 16; s++) write_slot(3, s, 3);
    for (int i = 0; i < 8; i++) issue(e, '0, "R9 R10");
  endtask

  task automatic t_write_same_cycle();
    logic [NB-1:0] e = only_q('1, 0, 4'b0000);
    int s = m_ptr[0];
    int nv = (m_tbl[0][s] + 2) % 4;
    issue(e, '0, "R9", 1, 0, s, nv);   // decision uses old entry
    for (int i = 0; i < 15; i++) issue(e, '0, "R9");  // slot comes round again
    issue(e, '0, "R9");
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rr_all();
    t_skip();
    t_idle();
    t_noreq();
    t_fallback();
    t_wrap();
    t_write();
    t_write_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule